// File: doc/BRIEF.md
# GPIO Output Driver with Clock Source Selection

This block drives the output half of a bank of general-purpose pins. It keeps one output data word that software changes only through two masked write ports: a set port that raises the bits named in its mask and a clear port that lowers them. Neither port needs a read-modify-write. Both ports return the stored word on their read side.

Each pin has its own output enable and its own source selection. A pin normally drives its data bit. It can instead drive one of several clock-generator outputs. It can also drive one of two recovered clocks. Each recovered-clock path picks one of four receive-lane strobes and divides it by 2 or by 4. Each lane clock reaches the block as a one-cycle enable strobe in the core clock domain, and the division is done with a small toggle counter, so the whole block runs on a single clock. The pad tristate is presented as a separate value and enable per pin.

Top module: `gpio_out_drv`

## Requirements
- R1: After reset the stored output word is all zeros, both readback ports return zero, every recovered-clock output is low, and pad_out is zero.
- R2: A cycle with set_wr high sets every stored bit whose set_mask bit is 1 and keeps the others, visible on the readback one clock later.
- R3: A cycle with clr_wr high clears every stored bit whose clr_mask bit is 1 and keeps the others, visible one clock later.
- R4: When set_wr and clr_wr are both high in one cycle, a bit named in both masks ends up 0, and a bit named only in set_mask ends up 1.
- R5: set_rdata and clr_rdata always carry the same value, which is the stored output word.
- R6: pad_oe[i] equals pin_oe[i], and pad_out[i] is 0 whenever pin_oe[i] is 0.
- R7: The recovered-clock select of pin i is pin_rec_sel[2i+1:2i]. With bit 0 of it clear, the pin drives its normal source. Code 01 drives recovered clock 0, and code 11 drives recovered clock 1.
- R8: With pin_clk_en[i] set and no recovered clock selected, the pin drives gen_clk[pin_clk_sel[i]]. pin_clk_sel packs two bits per pin, pin i at [2i+1:2i].
- R9: A recovered-clock selection overrides pin_clk_en when both are active.
- R10: Recovered-clock path k counts only strobes on lane_stb[rec_lane_sel[2k+1:2k]]. Strobes on other lanes leave it unchanged.
- R11: Each path counts its selected strobes modulo 4 from reset. Its output is the counter's low bit when rec_div4[k] is 0 (divide by 2), and its high bit when rec_div4[k] is 1 (divide by 4). The output changes on the clock after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| set_wr | input | 1 | Write strobe of the set port |
| set_mask | input | 24 | Bits to raise |
| clr_wr | input | 1 | Write strobe of the clear port |
| clr_mask | input | 24 | Bits to lower |
| set_rdata | output | 24 | Stored word read through the set port |
| clr_rdata | output | 24 | Stored word read through the clear port |
| pin_oe | input | 24 | Per-pin output enable |
| pin_clk_en | input | 24 | Per-pin clock-generator enable |
| pin_clk_sel | input | 48 | Per-pin clock-generator index, 2 bits per pin |
| pin_rec_sel | input | 48 | Per-pin recovered-clock select, 2 bits per pin |
| gen_clk | input | 4 | Clock-generator outputs, as core-clock levels |
| lane_stb | input | 4 | One-cycle strobe per receive-lane clock edge |
| rec_lane_sel | input | 4 | Lane index per recovered-clock path, 2 bits per path |
| rec_div4 | input | 2 | Per-path divider: 0 divides by 2, 1 divides by 4 |
| pad_out | output | 24 | Pad output value |
| pad_oe | output | 24 | Pad output enable |

## Verification
The assertions assume that every input is synchronous to clk and changes only between edges. They also assume that lane strobes are single-cycle pulses on lanes that exist. The divider property allows rec_div4 to change between cycles, and the stability checks let a strobe-free cycle show a change only when the divider bit itself moved. The bench drives every input on the falling edge. It pulses one lane at a time, and it changes the path configuration only while no strobe is active, so each count it predicts comes from a known sequence of strobes.

// File: rtl/gpio_out_pkg.sv
package gpio_out_pkg;
  localparam int REC_PATHS = 2;
  localparam int REC_SEL_W = 2;
  localparam int CNT_W     = 2;

  typedef enum logic [1:0] {
    SRC_DATA = 2'd0,
    SRC_GEN  = 2'd1,
    SRC_REC  = 2'd2
  } pin_src_e;
endpackage

// File: rtl/gpio_data_reg.sv
module gpio_data_reg #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_wr,
  input  logic [W-1:0] set_mask,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;
  logic         upd;

  // clear applied after set: clear wins on overlap
  always_comb begin
    upd   = set_wr | clr_wr;
    q_nxt = q;
    if (set_wr) q_nxt = q_nxt | set_mask;
    if (clr_wr) q_nxt = q_nxt & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_nxt;
  end
endmodule

// File: rtl/gpio_rec_div.sv
module gpio_rec_div
  import gpio_out_pkg::*;
#(
  parameter int NLANE = 4,
  localparam int LSW  = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NLANE-1:0] lane_stb,
  input  logic [LSW-1:0]   lane_sel,
  input  logic             div4,
  output logic             rec_clk
);
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             adv;

  always_comb begin
    adv     = lane_stb[lane_sel];
    cnt_nxt = cnt + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= cnt_nxt;
  end

  assign rec_clk = div4 ? cnt[1] : cnt[0];
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux
  import gpio_out_pkg::*;
#(
  parameter int NGEN = 4,
  localparam int GSW = (NGEN > 1) ? $clog2(NGEN) : 1
) (
  input  logic                 oe,
  input  logic                 dat,
  input  logic                 clk_en,
  input  logic [GSW-1:0]       clk_sel,
  input  logic [REC_SEL_W-1:0] rec_sel,
  input  logic [NGEN-1:0]      gen_clk,
  input  logic [REC_PATHS-1:0] rec_clk,
  output logic                 pad_o,
  output logic                 pad_en
);
  pin_src_e src;
  logic     val;

  always_comb begin
    if (rec_sel[0])  src = SRC_REC;
    else if (clk_en) src = SRC_GEN;
    else             src = SRC_DATA;

    case (src)
      SRC_REC: val = rec_clk[rec_sel[1]];
      SRC_GEN: val = gen_clk[clk_sel];
      default: val = dat;
    endcase

    pad_en = oe;
    pad_o  = oe & val;
  end
endmodule

// File: rtl/gpio_out_drv.sv
module gpio_out_drv
  import gpio_out_pkg::*;
#(
  parameter int NPIN  = 24,
  parameter int NGEN  = 4,
  parameter int NLANE = 4,
  localparam int GSW  = (NGEN > 1) ? $clog2(NGEN) : 1,
  localparam int LSW  = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_wr,
  input  logic [NPIN-1:0]           set_mask,
  input  logic                      clr_wr,
  input  logic [NPIN-1:0]           clr_mask,
  output logic [NPIN-1:0]           set_rdata,
  output logic [NPIN-1:0]           clr_rdata,
  input  logic [NPIN-1:0]           pin_oe,
  input  logic [NPIN-1:0]           pin_clk_en,
  input  logic [NPIN*GSW-1:0]       pin_clk_sel,
  input  logic [NPIN*REC_SEL_W-1:0] pin_rec_sel,
  input  logic [NGEN-1:0]           gen_clk,
  input  logic [NLANE-1:0]          lane_stb,
  input  logic [REC_PATHS*LSW-1:0]  rec_lane_sel,
  input  logic [REC_PATHS-1:0]      rec_div4,
  output logic [NPIN-1:0]           pad_out,
  output logic [NPIN-1:0]           pad_oe
);
  logic                 rst_meta, rst_sync;
  logic [NPIN-1:0]      dat_q;
  logic [REC_PATHS-1:0] rec_clk;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  gpio_data_reg #(.W(NPIN)) u_dat (
    .clk      (clk),
    .rst_n    (rst_sync),
    .set_wr   (set_wr),
    .set_mask (set_mask),
    .clr_wr   (clr_wr),
    .clr_mask (clr_mask),
    .q        (dat_q)
  );

  assign set_rdata = dat_q;
  assign clr_rdata = dat_q;

  for (genvar k = 0; k < REC_PATHS; k++) begin : g_rec
    gpio_rec_div #(.NLANE(NLANE)) u_div (
      .clk      (clk),
      .rst_n    (rst_sync),
      .lane_stb (lane_stb),
      .lane_sel (rec_lane_sel[k*LSW +: LSW]),
      .div4     (rec_div4[k]),
      .rec_clk  (rec_clk[k])
    );
  end

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    gpio_pin_mux #(.NGEN(NGEN)) u_mux (
      .oe      (pin_oe[i]),
      .dat     (dat_q[i]),
      .clk_en  (pin_clk_en[i]),
      .clk_sel (pin_clk_sel[i*GSW +: GSW]),
      .rec_sel (pin_rec_sel[i*REC_SEL_W +: REC_SEL_W]),
      .gen_clk (gen_clk),
      .rec_clk (rec_clk),
      .pad_o   (pad_out[i]),
      .pad_en  (pad_oe[i])
    );
  end
endmodule

// File: rtl/gpio_out_drv_chk.sv
module gpio_out_drv_chk
  import gpio_out_pkg::*;
#(
  parameter int NPIN  = 24,
  parameter int NGEN  = 4,
  parameter int NLANE = 4,
  localparam int GSW  = (NGEN > 1) ? $clog2(NGEN) : 1,
  localparam int LSW  = (NLANE > 1) ? $clog2(NLANE) : 1
) (
  input logic                      clk,
  input logic                      rst_sync,
  input logic                      set_wr,
  input logic [NPIN-1:0]           set_mask,
  input logic                      clr_wr,
  input logic [NPIN-1:0]           clr_mask,
  input logic [NPIN-1:0]           set_rdata,
  input logic [NPIN-1:0]           clr_rdata,
  input logic [NPIN-1:0]           pin_oe,
  input logic [NPIN-1:0]           pin_clk_en,
  input logic [NPIN*GSW-1:0]       pin_clk_sel,
  input logic [NPIN*REC_SEL_W-1:0] pin_rec_sel,
  input logic [NGEN-1:0]           gen_clk,
  input logic [NLANE-1:0]          lane_stb,
  input logic [REC_PATHS*LSW-1:0]  rec_lane_sel,
  input logic [REC_PATHS-1:0]      rec_div4,
  input logic [REC_PATHS-1:0]      rec_clk,
  input logic [NPIN-1:0]           pad_out,
  input logic [NPIN-1:0]           pad_oe
);
  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_sync)
    (set_wr && !clr_wr) |=> ((set_rdata & $past(set_mask)) == $past(set_mask))); // R2

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_sync)
    clr_wr |=> ((set_rdata & $past(clr_mask)) == '0)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    (!set_wr && !clr_wr) |=> $stable(set_rdata)); // R2

  AST_READBACK: assert property (@(posedge clk) disable iff (!rst_sync)
    set_rdata == clr_rdata); // R5

  AST_OE_PASS: assert property (@(posedge clk) disable iff (!rst_sync)
    (pad_oe == pin_oe) && ((pad_out & ~pin_oe) == '0)); // R6

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    AST_PIN_DATA: assert property (@(posedge clk) disable iff (!rst_sync)
      (pin_oe[i] && !pin_rec_sel[i*2] && !pin_clk_en[i]) |-> (pad_out[i] == set_rdata[i])); // R7
    AST_PIN_GEN: assert property (@(posedge clk) disable iff (!rst_sync)
      (pin_oe[i] && !pin_rec_sel[i*2] && pin_clk_en[i])
        |-> (pad_out[i] == gen_clk[pin_clk_sel[i*GSW +: GSW]])); // R8
    AST_PIN_REC: assert property (@(posedge clk) disable iff (!rst_sync)
      (pin_oe[i] && pin_rec_sel[i*2]) |-> (pad_out[i] == rec_clk[pin_rec_sel[i*2+1]])); // R9
  end

  for (genvar k = 0; k < REC_PATHS; k++) begin : g_path
    AST_REC_QUIET: assert property (@(posedge clk) disable iff (!rst_sync)
      !lane_stb[rec_lane_sel[k*LSW +: LSW]]
        |=> ((rec_div4[k] != $past(rec_div4[k])) || $stable(rec_clk[k]))); // R10
    AST_REC_DIV2: assert property (@(posedge clk) disable iff (!rst_sync)
      (lane_stb[rec_lane_sel[k*LSW +: LSW]] && !rec_div4[k])
        |=> (rec_div4[k] || (rec_clk[k] != $past(rec_clk[k])))); // R11
  end
endmodule

bind gpio_out_drv gpio_out_drv_chk #(.NPIN(NPIN), .NGEN(NGEN), .NLANE(NLANE)) u_chk (
  .clk          (clk),
  .rst_sync     (rst_sync),
  .set_wr       (set_wr),
  .set_mask     (set_mask),
  .clr_wr       (clr_wr),
  .clr_mask     (clr_mask),
  .set_rdata    (set_rdata),
  .clr_rdata    (clr_rdata),
  .pin_oe       (pin_oe),
  .pin_clk_en   (pin_clk_en),
  .pin_clk_sel  (pin_clk_sel),
  .pin_rec_sel  (pin_rec_sel),
  .gen_clk      (gen_clk),
  .lane_stb     (lane_stb),
  .rec_lane_sel (rec_lane_sel),
  .rec_div4     (rec_div4),
  .rec_clk      (rec_clk),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe)
);

// File: tb/tb_gpio_out_drv.sv
module tb_gpio_out_drv;
  localparam int NPIN = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              set_wr, clr_wr;
  logic [NPIN-1:0]   set_mask, clr_mask, set_rdata, clr_rdata;
  logic [NPIN-1:0]   pin_oe, pin_clk_en, pad_out, pad_oe;
  logic [2*NPIN-1:0] pin_clk_sel, pin_rec_sel;
  logic [3:0]        gen_clk, lane_stb, rec_lane_sel;
  logic [1:0]        rec_div4;

  int checks = 0;
  int errors = 0;
  logic [NPIN-1:0] exp_data;
  int cnt0 = 0;
  int cnt1 = 0;

  always #5 clk = ~clk;

  gpio_out_drv dut (
    .clk(clk), .rst_n(rst_n),
    .set_wr(set_wr), .set_mask(set_mask), .clr_wr(clr_wr), .clr_mask(clr_mask),
    .set_rdata(set_rdata), .clr_rdata(clr_rdata),
    .pin_oe(pin_oe), .pin_clk_en(pin_clk_en), .pin_clk_sel(pin_clk_sel),
    .pin_rec_sel(pin_rec_sel), .gen_clk(gen_clk), .lane_stb(lane_stb),
    .rec_lane_sel(rec_lane_sel), .rec_div4(rec_div4),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [NPIN-1:0] sm,
                    input logic c, input logic [NPIN-1:0] cm);
    @(negedge clk);
    set_wr = s; set_mask = sm; clr_wr = c; clr_mask = cm;
    @(negedge clk);
    set_wr = 1'b0; clr_wr = 1'b0;
    if (s) exp_data = exp_data | sm;
    if (c) exp_data = exp_data & ~cm;
  endtask

  task automatic pulse(input int lane);
    @(negedge clk);
    lane_stb = 4'(1 << lane);
    @(negedge clk);
    lane_stb = '0;
    if (int'(rec_lane_sel[1:0]) == lane) cnt0++;
    if (int'(rec_lane_sel[3:2]) == lane) cnt1++;
  endtask

  function automatic logic rec_exp(input int k);
    int c;
    c = (k == 0) ? cnt0 : cnt1;
    return rec_div4[k] ? logic'((c >> 1) & 1) : logic'(c & 1);
  endfunction

  task automatic t_reset;
    chk("R1 set_rdata", 32'(set_rdata), 0);
    chk("R1 clr_rdata", 32'(clr_rdata), 0);
    chk("R1 pad_out",   32'(pad_out),   0);
  endtask

  task automatic t_set_clr;
    wr(1'b1, 24'h00F00F, 1'b0, '0);
    chk("R2 set mask", 32'(set_rdata), 32'(exp_data));
    wr(1'b1, 24'h000100, 1'b0, '0);
    chk("R2 set keeps others", 32'(set_rdata), 32'h00F10F);
    wr(1'b0, '0, 1'b1, 24'h00000C);
    chk("R3 clear mask", 32'(set_rdata), 32'h00F103);
    wr(1'b1, 24'h0000F0, 1'b1, 24'h000030);
    chk("R4 both same cycle", 32'(set_rdata), 32'h00F1C3);
    chk("R5 clr port readback", 32'(clr_rdata), 32'(exp_data));
    chk("R5 ports equal", 32'(clr_rdata), 32'(set_rdata));
  endtask

  task automatic t_oe;
    @(negedge clk);
    pin_oe = 24'h0000FF;
    #1;
    chk("R6 pad_oe", 32'(pad_oe), 32'h0000FF);
    chk("R6 pad_out masked", 32'(pad_out), 32'(exp_data & 24'h0000FF));
    pin_oe = '1;
    #1;
    chk("R7 data source", 32'(pad_out), 32'(exp_data));
  endtask

  task automatic t_gen;
    @(negedge clk);
    pin_clk_en[2] = 1'b1; pin_clk_sel[5:4] = 2'd2;
    gen_clk = 4'b0100;
    #1 chk("R8 gen high", 32'(pad_out[2]), 1);
    gen_clk = 4'b1011;
    #1 chk("R8 gen low", 32'(pad_out[2]), 0);
    pin_rec_sel[9:8] = 2'b10;
    #1 chk("R7 code 10 is normal", 32'(pad_out[4]), 32'(exp_data[4]));
  endtask

  task automatic t_rec;
    @(negedge clk);
    rec_lane_sel = {2'd3, 2'd2}; rec_div4 = 2'b10;
    pin_rec_sel[1:0] = 2'b01; pin_rec_sel[3:2] = 2'b11;
    pin_clk_en[3] = 1'b1; pin_clk_sel[7:6] = 2'd0; pin_rec_sel[7:6] = 2'b01;
    gen_clk = 4'b0001;
    #1 chk("R11 path0 after reset", 32'(pad_out[0]), 0);
    pulse(2);
    chk("R11 div2 toggles", 32'(pad_out[0]), 32'(rec_exp(0)));
    chk("R9 rec overrides gen", 32'(pad_out[3]), 32'(rec_exp(0)));
    pulse(1);
    chk("R10 other lane ignored", 32'(pad_out[0]), 32'(rec_exp(0)));
    pulse(2);
    chk("R11 div2 second toggle", 32'(pad_out[0]), 32'(rec_exp(0)));
    chk("R9 rec overrides gen low", 32'(pad_out[3]), 32'(rec_exp(0)));
    for (int n = 0; n < 4; n++) begin
      pulse(3);
      chk("R11 div4 path1", 32'(pad_out[1]), 32'(rec_exp(1)));
    end
    pulse(0);
    chk("R10 lane0 leaves path1", 32'(pad_out[1]), 32'(rec_exp(1)));
  endtask

  initial begin
    rst_n = 1'b0;
    set_wr = 1'b0; clr_wr = 1'b0; set_mask = '0; clr_mask = '0;
    pin_oe = '1; pin_clk_en = '0; pin_clk_sel = '0; pin_rec_sel = '0;
    gen_clk = '0; lane_stb = '0; rec_lane_sel = '0; rec_div4 = '0;
    exp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset;
    t_set_clr;
    t_oe;
    t_gen;
    t_rec;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule